// File: doc/BRIEF.md
# Single-Cycle MIPS-Subset Processor Core

This block is a processor core that finishes one instruction every clock cycle. It fetches a 32-bit word at the program counter, decodes it, reads two source registers, runs the arithmetic unit, reaches data memory, writes back and picks the next program counter, all inside the same cycle. Code and data share one byte-addressed store. The legal address space is 64 KB. Words are held with the most significant byte at the lowest address.

The core runs fourteen instructions: add, sub, and, or, slt, sltu, addi, slti, sltiu, lui, lw, sw, beq and j. It has no exception mechanism. When it meets an instruction outside this set, a misaligned or out-of-range data access, or an out-of-range control target, it raises a sticky stop flag. From then on the core changes no architectural state until reset. The write-back and store buses of the current instruction are visible as outputs, so an observer can follow each committed result. The backing store covers the low `2**STORE_AW` bytes of the address space, and upper address bits alias onto it. A test harness fills the store directly while reset is held.

Top module: `scc_core`

## Requirements
- R1: While reset is asserted and after it is released, the program counter is 0x4000 and the stop flag is low. Every register reads zero until it is written.
- R2: Opcode 0 with funct 0x20, 0x22, 0x24 or 0x25 writes rs+rt, rs-rt, rs AND rt or rs OR rt to register rd (bits 15:11). rs is bits 25:21 and rt is bits 20:16.
- R3: funct 0x2a (slt) and funct 0x2b (sltu) write 1 to rd when rs is less than rt, compared signed for slt and unsigned for sltu, and write 0 otherwise. Opcodes 0x0A (slti) and 0x0B (sltiu) do the same with the sign-extended 16-bit immediate and write to rt.
- R4: Opcode 0x08 (addi) writes rs plus the sign-extended immediate to rt. Opcode 0x0F (lui) writes the immediate shifted left by 16 to rt.
- R5: Opcode 0x23 (lw) loads into rt the word at rs plus the sign-extended immediate. Opcode 0x2B (sw) stores rt at that address. The byte at the word address is the most significant byte of the word.
- R6: Opcode 0x04 (beq) moves the PC to PC+4+(sign-extended offset shifted left by 2) when rs equals rt, and to PC+4 otherwise.
- R7: Opcode 0x02 (j) moves the PC to bits 31:28 of PC+4, followed by the 26-bit field, followed by two zero bits.
- R8: A write aimed at register 0 has no effect, and register 0 always reads zero.
- R9: A fetched word outside the supported set, including the all-zero word and an opcode-0 word with an unsupported funct, raises the stop flag and commits nothing.
- R10: A lw or sw whose effective address is not a multiple of 4 raises the stop flag, and no store takes place.
- R11: A lw or sw effective address, a j target or a taken beq target at or above 0x10000 raises the stop flag and commits nothing.
- R12: The stop flag rises on the edge that ends the faulting instruction and stays high until reset. While it is high the PC, the registers and memory do not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| halt_o | output | 1 | Sticky stop flag |
| pc_o | output | 32 | Address of the instruction being executed |
| wb_en_o | output | 1 | A register write commits at the coming edge |
| wb_addr_o | output | 5 | Destination register of the write |
| wb_data_o | output | 32 | Value being written |
| st_en_o | output | 1 | A memory store commits at the coming edge |
| st_addr_o | output | 32 | Byte address of the store |
| st_data_o | output | 32 | Word being stored |

## Verification
An instruction's results show on the write-back and store outputs during the same cycle in which `pc_o` holds its address. They take effect on the rising edge that ends that cycle, and `pc_o` moves to the next address on that same edge. The stop flag is registered, so it rises one cycle after the faulting instruction is shown. The bench queues, per cycle, the expected PC, the flag level and the write and store buses. A falling-edge monitor pops one entry each cycle, so every value is read half a period after the edge that produced it. Register effects are seen through the write-back data of later instructions that read them.

// File: rtl/scc_pkg.sv
package scc_pkg;

   localparam int unsigned XLEN = 32;

   typedef enum logic [2:0] {
      ALU_ADD,
      ALU_SUB,
      ALU_AND,
      ALU_OR,
      ALU_SLT,
      ALU_SLTU,
      ALU_LUI
   } alu_op_e;

   typedef struct packed {
      logic    legal;
      logic    reg_we;
      logic    dst_rd;
      logic    use_imm;
      logic    mem_rd;
      logic    mem_wr;
      logic    branch;
      logic    jump;
      alu_op_e alu_op;
   } ctrl_t;

   localparam logic [5:0] OPC_REG   = 6'h00;
   localparam logic [5:0] OPC_JMP   = 6'h02;
   localparam logic [5:0] OPC_BEQ   = 6'h04;
   localparam logic [5:0] OPC_ADDI  = 6'h08;
   localparam logic [5:0] OPC_SLTI  = 6'h0A;
   localparam logic [5:0] OPC_SLTIU = 6'h0B;
   localparam logic [5:0] OPC_LUI   = 6'h0F;
   localparam logic [5:0] OPC_LW    = 6'h23;
   localparam logic [5:0] OPC_SW    = 6'h2B;

   localparam logic [5:0] FN_ADD  = 6'h20;
   localparam logic [5:0] FN_SUB  = 6'h22;
   localparam logic [5:0] FN_AND  = 6'h24;
   localparam logic [5:0] FN_OR   = 6'h25;
   localparam logic [5:0] FN_SLT  = 6'h2A;
   localparam logic [5:0] FN_SLTU = 6'h2B;

endpackage

// File: rtl/scc_decode.sv
module scc_decode
   import scc_pkg::*;
(
   input  logic [5:0] opcode_i,
   input  logic [5:0] funct_i,
   output ctrl_t      ctrl_o
);

   always_comb begin
      ctrl_o        = '0;
      ctrl_o.alu_op = ALU_ADD;
      case (opcode_i)
         OPC_REG: begin
            ctrl_o.legal  = 1'b1;
            ctrl_o.reg_we = 1'b1;
            ctrl_o.dst_rd = 1'b1;
            case (funct_i)
               FN_ADD:  ctrl_o.alu_op = ALU_ADD;
               FN_SUB:  ctrl_o.alu_op = ALU_SUB;
               FN_AND:  ctrl_o.alu_op = ALU_AND;
               FN_OR:   ctrl_o.alu_op = ALU_OR;
               FN_SLT:  ctrl_o.alu_op = ALU_SLT;
               FN_SLTU: ctrl_o.alu_op = ALU_SLTU;
               default: begin
                  ctrl_o.legal  = 1'b0;
                  ctrl_o.reg_we = 1'b0;
               end
            endcase
         end
         OPC_ADDI, OPC_SLTI, OPC_SLTIU, OPC_LUI: begin
            ctrl_o.legal   = 1'b1;
            ctrl_o.reg_we  = 1'b1;
            ctrl_o.use_imm = 1'b1;
            case (opcode_i)
               OPC_SLTI:  ctrl_o.alu_op = ALU_SLT;
               OPC_SLTIU: ctrl_o.alu_op = ALU_SLTU;
               OPC_LUI:   ctrl_o.alu_op = ALU_LUI;
               default:   ctrl_o.alu_op = ALU_ADD;
            endcase
         end
         OPC_LW: begin
            ctrl_o.legal   = 1'b1;
            ctrl_o.reg_we  = 1'b1;
            ctrl_o.use_imm = 1'b1;
            ctrl_o.mem_rd  = 1'b1;
         end
         OPC_SW: begin
            ctrl_o.legal   = 1'b1;
            ctrl_o.use_imm = 1'b1;
            ctrl_o.mem_wr  = 1'b1;
         end
         OPC_BEQ: begin
            ctrl_o.legal  = 1'b1;
            ctrl_o.branch = 1'b1;
            ctrl_o.alu_op = ALU_SUB;
         end
         OPC_JMP: begin
            ctrl_o.legal = 1'b1;
            ctrl_o.jump  = 1'b1;
         end
         default: ctrl_o.legal = 1'b0;
      endcase
   end

endmodule

// File: rtl/scc_alu.sv
module scc_alu
   import scc_pkg::*;
#(
   parameter int unsigned W = 32
) (
   input  logic [W-1:0] a_i,
   input  logic [W-1:0] b_i,
   input  alu_op_e      op_i,
   output logic [W-1:0] y_o,
   output logic         zero_o
);

   localparam int unsigned HALF = W / 2;

   always_comb begin
      case (op_i)
         ALU_SUB:  y_o = a_i - b_i;
         ALU_AND:  y_o = a_i & b_i;
         ALU_OR:   y_o = a_i | b_i;
         ALU_SLT:  y_o = {{(W-1){1'b0}}, ($signed(a_i) < $signed(b_i))};
         ALU_SLTU: y_o = {{(W-1){1'b0}}, (a_i < b_i)};
         ALU_LUI:  y_o = b_i << HALF;
         default:  y_o = a_i + b_i;
      endcase
   end

   assign zero_o = (y_o == '0);

endmodule

// File: rtl/scc_regfile.sv
module scc_regfile #(
   parameter  int unsigned W  = 32,
   parameter  int unsigned N  = 32,
   parameter  int unsigned RP = 2,
   localparam int unsigned AW = $clog2(N)
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic [RP-1:0][AW-1:0]  raddr_i,
   output logic [RP-1:0][W-1:0]   rdata_o,
   input  logic                   we_i,
   input  logic [AW-1:0]          waddr_i,
   input  logic [W-1:0]           wdata_i
);

   logic [W-1:0] rf_q [N];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < N; i++) rf_q[i] <= '0;
      end else if (we_i && (waddr_i != '0)) begin
         rf_q[waddr_i] <= wdata_i;
      end
   end

   generate
      for (genvar p = 0; p < RP; p++) begin : g_rport
         assign rdata_o[p] = (raddr_i[p] == '0) ? '0 : rf_q[raddr_i[p]];
      end
   endgenerate

endmodule

// File: rtl/scc_mem.sv
module scc_mem #(
   parameter  int unsigned AW    = 12,
   localparam int unsigned BYTES = 1 << AW,
   localparam int unsigned WA    = AW - 2
) (
   input  logic          clk,
   input  logic [WA-1:0] iaddr_i,
   output logic [31:0]   idata_o,
   input  logic [WA-1:0] daddr_i,
   output logic [31:0]   drdata_o,
   input  logic          we_i,
   input  logic [31:0]   dwdata_i
);

   logic [7:0] mem_q [BYTES];

   generate
      for (genvar l = 0; l < 4; l++) begin : g_lane
         localparam int unsigned SH = 8 * (3 - l);
         assign idata_o[SH +: 8]  = mem_q[{iaddr_i, 2'(l)}];
         assign drdata_o[SH +: 8] = mem_q[{daddr_i, 2'(l)}];
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (we_i) begin
         for (int l = 0; l < 4; l++) mem_q[{daddr_i, 2'(l)}] <= dwdata_i[8*(3-l) +: 8];
      end
   end

endmodule

// File: rtl/scc_core.sv
module scc_core
   import scc_pkg::*;
#(
   parameter int unsigned ADDR_W   = 16,
   parameter int unsigned STORE_AW = 12,
   parameter logic [31:0] RESET_PC = 32'h0000_4000
) (
   input  logic        clk,
   input  logic        rst_n,
   output logic        halt_o,
   output logic [31:0] pc_o,
   output logic        wb_en_o,
   output logic [4:0]  wb_addr_o,
   output logic [31:0] wb_data_o,
   output logic        st_en_o,
   output logic [31:0] st_addr_o,
   output logic [31:0] st_data_o
);

   localparam int unsigned NREG = 32;
   localparam int unsigned RAW  = $clog2(NREG);

   generate
      if (ADDR_W < 8 || ADDR_W > 31) begin : g_bad_addr_w
         $error("scc_core: ADDR_W out of range");
      end
      if (STORE_AW < 4 || STORE_AW > ADDR_W) begin : g_bad_store_aw
         $error("scc_core: STORE_AW must lie between 4 and ADDR_W");
      end
      if (RESET_PC[1:0] != 2'b00) begin : g_bad_reset_pc
         $error("scc_core: RESET_PC must be word aligned");
      end
   endgenerate

   logic [31:0] pc_q, pc_plus4, br_target, j_target, next_pc;
   logic [31:0] instr, sext_imm, alu_b, alu_y, mem_rdata;
   logic        halt_q, alu_zero;
   ctrl_t       ctrl;

   logic [1:0][RAW-1:0] rf_raddr;
   logic [1:0][31:0]    rf_rdata;
   logic [RAW-1:0]      dst;

   // fetch
   scc_mem #(.AW(STORE_AW)) u_mem (
      .clk      (clk),
      .iaddr_i  (pc_q[STORE_AW-1:2]),
      .idata_o  (instr),
      .daddr_i  (alu_y[STORE_AW-1:2]),
      .drdata_o (mem_rdata),
      .we_i     (st_en_o),
      .dwdata_i (rf_rdata[1])
   );

   // decode and operand read
   scc_decode u_dec (
      .opcode_i (instr[31:26]),
      .funct_i  (instr[5:0]),
      .ctrl_o   (ctrl)
   );

   assign rf_raddr[0] = instr[25:21];
   assign rf_raddr[1] = instr[20:16];
   assign dst         = ctrl.dst_rd ? instr[15:11] : instr[20:16];
   assign sext_imm    = {{16{instr[15]}}, instr[15:0]};

   scc_regfile #(.W(XLEN), .N(NREG), .RP(2)) u_rf (
      .clk     (clk),
      .rst_n   (rst_n),
      .raddr_i (rf_raddr),
      .rdata_o (rf_rdata),
      .we_i    (wb_en_o),
      .waddr_i (wb_addr_o),
      .wdata_i (wb_data_o)
   );

   // execute
   assign alu_b = ctrl.use_imm ? sext_imm : rf_rdata[1];

   scc_alu #(.W(XLEN)) u_alu (
      .a_i    (rf_rdata[0]),
      .b_i    (alu_b),
      .op_i   (ctrl.alu_op),
      .y_o    (alu_y),
      .zero_o (alu_zero)
   );

   // control targets
   logic take_br;
   assign pc_plus4  = pc_q + 32'd4;
   assign br_target = pc_plus4 + {sext_imm[29:0], 2'b00};
   assign j_target  = {pc_plus4[31:28], instr[25:0], 2'b00};
   assign take_br   = ctrl.branch & alu_zero;
   assign next_pc   = ctrl.jump ? j_target : (take_br ? br_target : pc_plus4);

   // fault detection
   logic fetch_oob, data_bad, jmp_bad, br_bad, fault, commit;
   assign fetch_oob = (pc_q >> ADDR_W) != '0;
   assign data_bad  = (ctrl.mem_rd | ctrl.mem_wr)
                      & ((alu_y[1:0] != 2'b00) | ((alu_y >> ADDR_W) != '0));
   assign jmp_bad   = ctrl.jump & ((j_target[1:0] != 2'b00) | ((j_target >> ADDR_W) != '0));
   assign br_bad    = take_br & ((br_target[1:0] != 2'b00) | ((br_target >> ADDR_W) != '0));
   assign fault     = ~ctrl.legal | fetch_oob | data_bad | jmp_bad | br_bad;
   assign commit    = ~halt_q & ~fault;

   // write-back and store buses
   assign wb_addr_o = dst;
   assign wb_data_o = ctrl.mem_rd ? mem_rdata : alu_y;
   assign wb_en_o   = commit & ctrl.reg_we & (dst != '0);
   assign st_en_o   = commit & ctrl.mem_wr;
   assign st_addr_o = alu_y;
   assign st_data_o = rf_rdata[1];

   // program counter and stop flag
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pc_q   <= RESET_PC;
         halt_q <= 1'b0;
      end else begin
         if (commit) pc_q <= next_pc;
         halt_q <= halt_q | fault;
      end
   end

   assign pc_o   = pc_q;
   assign halt_o = halt_q;

   logic unused_bits;
   assign unused_bits = ^{instr[10:6], pc_q[1:0]};

endmodule

// File: rtl/scc_core_chk.sv
module scc_core_chk #(
   parameter int unsigned ADDR_W = 16
) (
   input logic        clk,
   input logic        rst_n,
   input logic        halt_o,
   input logic [31:0] pc_o,
   input logic        wb_en_o,
   input logic [4:0]  wb_addr_o,
   input logic        st_en_o,
   input logic [31:0] st_addr_o
);

   p_halt_sticky_r12: assert property (@(posedge clk) disable iff (!rst_n)
      halt_o |=> halt_o);

   p_halt_pc_frozen_r12: assert property (@(posedge clk) disable iff (!rst_n)
      halt_o |=> $stable(pc_o));

   p_halt_no_commit_r12: assert property (@(posedge clk) disable iff (!rst_n)
      halt_o |-> (!wb_en_o && !st_en_o));

   p_halt_rise_holds_pc_r9: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(halt_o) |-> (pc_o == $past(pc_o)));

   p_no_r0_write_r8: assert property (@(posedge clk) disable iff (!rst_n)
      wb_en_o |-> (wb_addr_o != 5'd0));

   p_store_aligned_r10: assert property (@(posedge clk) disable iff (!rst_n)
      st_en_o |-> (st_addr_o[1:0] == 2'b00));

   p_store_in_range_r11: assert property (@(posedge clk) disable iff (!rst_n)
      st_en_o |-> ((st_addr_o >> ADDR_W) == 32'd0));

   p_pc_aligned_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !halt_o |-> (pc_o[1:0] == 2'b00));

endmodule

bind scc_core scc_core_chk #(.ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/scc_core_bench.sv
`timescale 1ns/1ps
module scc_core_bench;

   localparam int unsigned STORE_AW = 12;
   localparam int unsigned BYTES    = 1 << STORE_AW;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        halt_o, wb_en_o, st_en_o;
   logic [31:0] pc_o, wb_data_o, st_addr_o, st_data_o;
   logic [4:0]  wb_addr_o;

   always #4 clk = ~clk;

   scc_core #(.ADDR_W(16), .STORE_AW(STORE_AW), .RESET_PC(32'h0000_4000)) u_scc_core (
      .clk       (clk),
      .rst_n     (rst_n),
      .halt_o    (halt_o),
      .pc_o      (pc_o),
      .wb_en_o   (wb_en_o),
      .wb_addr_o (wb_addr_o),
      .wb_data_o (wb_data_o),
      .st_en_o   (st_en_o),
      .st_addr_o (st_addr_o),
      .st_data_o (st_data_o)
   );

   typedef struct packed {
      logic [31:0] pc;
      logic        halt;
      logic        wb_en;
      logic [4:0]  wb_addr;
      logic [31:0] wb_data;
      logic        st_en;
      logic [31:0] st_addr;
      logic [31:0] st_data;
   } item_t;

   item_t exp_q[$];
   string req_q[$];
   int    checks = 0;
   int    errors = 0;
   bit    mon_on = 1'b0;
   bit    done   = 1'b0;

   task automatic chk(input bit ok, input string req, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s actual %h expected %h", req, what, act, exp);
      end
   endtask

   // scoreboard producers
   task automatic push(input item_t it, input string req);
      exp_q.push_back(it);
      req_q.push_back(req);
   endtask

   task automatic exp_plain(input logic [31:0] pc, input string req);
      item_t it = '0;
      it.pc = pc;
      push(it, req);
   endtask

   task automatic exp_wb(input logic [31:0] pc, input logic [4:0] rd,
                         input logic [31:0] val, input string req);
      item_t it = '0;
      it.pc = pc; it.wb_en = 1'b1; it.wb_addr = rd; it.wb_data = val;
      push(it, req);
   endtask

   task automatic exp_st(input logic [31:0] pc, input logic [31:0] a,
                         input logic [31:0] d, input string req);
      item_t it = '0;
      it.pc = pc; it.st_en = 1'b1; it.st_addr = a; it.st_data = d;
      push(it, req);
   endtask

   task automatic exp_halted(input logic [31:0] pc, input int n, input string req);
      for (int i = 0; i < n; i++) begin
         item_t it = '0;
         it.pc = pc; it.halt = 1'b1;
         push(it, req);
      end
   endtask

   // monitor: one expected item per cycle, sampled on the falling edge
   always @(negedge clk) begin
      if (mon_on && exp_q.size() != 0) begin
         item_t it;
         string rq;
         it = exp_q.pop_front();
         rq = req_q.pop_front();
         chk(pc_o == it.pc, rq, "pc", pc_o, it.pc);
         chk(halt_o == it.halt, rq, "halt", 32'(halt_o), 32'(it.halt));
         chk(wb_en_o == it.wb_en, rq, "wb_en", 32'(wb_en_o), 32'(it.wb_en));
         if (it.wb_en) begin
            chk(wb_addr_o == it.wb_addr, rq, "wb_addr", 32'(wb_addr_o), 32'(it.wb_addr));
            chk(wb_data_o == it.wb_data, rq, "wb_data", wb_data_o, it.wb_data);
         end
         chk(st_en_o == it.st_en, rq, "st_en", 32'(st_en_o), 32'(it.st_en));
         if (it.st_en) begin
            chk(st_addr_o == it.st_addr, rq, "st_addr", st_addr_o, it.st_addr);
            chk(st_data_o == it.st_data, rq, "st_data", st_data_o, it.st_data);
         end
      end
   end

   // memory preload (only while reset is held)
   task automatic put_byte(input logic [31:0] a, input logic [7:0] b);
      u_scc_core.u_mem.mem_q[a[STORE_AW-1:0]] = b;
   endtask

   task automatic put_word(input logic [31:0] a, input logic [31:0] w);
      put_byte(a,     w[31:24]);
      put_byte(a + 1, w[23:16]);
      put_byte(a + 2, w[15:8]);
      put_byte(a + 3, w[7:0]);
   endtask

   task automatic clear_mem();
      for (int i = 0; i < BYTES; i++) u_scc_core.u_mem.mem_q[i] = 8'h00;
   endtask

   task automatic run_prog();
      @(negedge clk);
      chk(pc_o == 32'h4000, "R1", "reset pc", pc_o, 32'h4000);
      chk(halt_o == 1'b0, "R1", "reset halt", 32'(halt_o), 32'd0);
      @(posedge clk);
      #1 rst_n = 1'b1;
      mon_on = 1'b1;
      while (exp_q.size() != 0) @(negedge clk);
      #1 mon_on = 1'b0;
      @(posedge clk);
      #1 rst_n = 1'b0;
   endtask

   initial begin
      // program 1: arithmetic, compares, memory, branches, jump, zero word
      clear_mem();
      put_word(32'h4000, 32'h20010005);  // addi r1,r0,5
      put_word(32'h4004, 32'h2002FFFD);  // addi r2,r0,-3
      put_word(32'h4008, 32'h00221820);  // add r3,r1,r2
      put_word(32'h400C, 32'h00222022);  // sub r4,r1,r2
      put_word(32'h4010, 32'h00222824);  // and r5,r1,r2
      put_word(32'h4014, 32'h00223025);  // or r6,r1,r2
      put_word(32'h4018, 32'h0041382A);  // slt r7,r2,r1
      put_word(32'h401C, 32'h0041402B);  // sltu r8,r2,r1
      put_word(32'h4020, 32'h2849FFFE);  // slti r9,r2,-2
      put_word(32'h4024, 32'h2C2AFFFF);  // sltiu r10,r1,-1
      put_word(32'h4028, 32'h3C0B1234);  // lui r11,0x1234
      put_word(32'h402C, 32'h00210020);  // add r0,r1,r1
      put_word(32'h4030, 32'h00016020);  // add r12,r0,r1
      put_word(32'h4034, 32'h8C0D0800);  // lw r13,0x800(r0)
      put_word(32'h4038, 32'hAC0B0804);  // sw r11,0x804(r0)
      put_word(32'h403C, 32'h8C0E0804);  // lw r14,0x804(r0)
      put_word(32'h4040, 32'h102C0001);  // beq r1,r12,+1 (taken)
      put_word(32'h4044, 32'h200F0001);  // skipped
      put_word(32'h4048, 32'h10220005);  // beq r1,r2,+5 (not taken)
      put_word(32'h404C, 32'h08001016);  // j 0x4058
      put_word(32'h4058, 32'h1000FFFD);  // beq r0,r0,-3 -> 0x4050
      put_byte(32'h0800, 8'hAA);
      put_byte(32'h0801, 8'hBB);
      put_byte(32'h0802, 8'hCC);
      put_byte(32'h0803, 8'hDD);

      exp_wb(32'h4000, 5'd1,  32'h00000005, "R4");
      exp_wb(32'h4004, 5'd2,  32'hFFFFFFFD, "R4");
      exp_wb(32'h4008, 5'd3,  32'h00000002, "R2");
      exp_wb(32'h400C, 5'd4,  32'h00000008, "R2");
      exp_wb(32'h4010, 5'd5,  32'h00000005, "R2");
      exp_wb(32'h4014, 5'd6,  32'hFFFFFFFD, "R2");
      exp_wb(32'h4018, 5'd7,  32'h00000001, "R3");
      exp_wb(32'h401C, 5'd8,  32'h00000000, "R3");
      exp_wb(32'h4020, 5'd9,  32'h00000001, "R3");
      exp_wb(32'h4024, 5'd10, 32'h00000001, "R3");
      exp_wb(32'h4028, 5'd11, 32'h12340000, "R4");
      exp_plain(32'h402C, "R8");
      exp_wb(32'h4030, 5'd12, 32'h00000005, "R8");
      exp_wb(32'h4034, 5'd13, 32'hAABBCCDD, "R5");
      exp_st(32'h4038, 32'h00000804, 32'h12340000, "R5");
      exp_wb(32'h403C, 5'd14, 32'h12340000, "R5");
      exp_plain(32'h4040, "R6");
      exp_plain(32'h4048, "R6");
      exp_plain(32'h404C, "R7");
      exp_plain(32'h4058, "R7");
      exp_plain(32'h4050, "R6");
      exp_halted(32'h4050, 3, "R9");
      run_prog();

      // program 2: registers cleared by reset, unsupported funct
      clear_mem();
      put_word(32'h4000, 32'h00211820);  // add r3,r1,r1
      put_word(32'h4004, 32'h20010008);  // addi r1,r0,8
      put_word(32'h4008, 32'h00211027);  // funct 0x27: unsupported
      exp_wb(32'h4000, 5'd3, 32'h00000000, "R1");
      exp_wb(32'h4004, 5'd1, 32'h00000008, "R4");
      exp_plain(32'h4008, "R9");
      exp_halted(32'h4008, 3, "R12");
      run_prog();

      // program 3: misaligned load
      clear_mem();
      put_word(32'h4000, 32'h20010802);  // addi r1,r0,0x802
      put_word(32'h4004, 32'h8C220000);  // lw r2,0(r1)
      exp_wb(32'h4000, 5'd1, 32'h00000802, "R4");
      exp_plain(32'h4004, "R10");
      exp_halted(32'h4004, 2, "R10");
      run_prog();

      // program 4: store beyond the address space
      clear_mem();
      put_word(32'h4000, 32'h3C010001);  // lui r1,1
      put_word(32'h4004, 32'hAC200000);  // sw r0,0(r1)
      exp_wb(32'h4000, 5'd1, 32'h00010000, "R4");
      exp_plain(32'h4004, "R11");
      exp_halted(32'h4004, 2, "R11");
      run_prog();

      // program 5: jump target beyond the address space
      clear_mem();
      put_word(32'h4000, 32'h08004000);  // j 0x10000
      exp_plain(32'h4000, "R11");
      exp_halted(32'h4000, 2, "R11");
      run_prog();

      // program 6: misaligned store
      clear_mem();
      put_word(32'h4000, 32'hAC000002);  // sw r0,2(r0)
      exp_plain(32'h4000, "R10");
      exp_halted(32'h4000, 2, "R10");
      run_prog();

      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      #(200000 * 8);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL R12 watchdog actual running expected finished");
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

endmodule